// File: doc/BRIEF.md
# Two-Level SMI Status Controller

This block gathers power-management interrupt events into a two-tier tree of sticky status registers. It drives one active-low interrupt line, `smi_n`, towards the processor. Second-tier sources are two general-purpose timer expiries, three user-defined address traps and one PCI address trap. Any event from that group sets a single summary bit (bit 9) in the top tier. The remaining top-tier bits are fed directly by other source groups.

Handler software reads the tree through a simple 16-bit read port addressed by I/O offset. Each tier has two views that return the same data:

| Tier | Mirror view (no side effect) | Read-to-clear view |
|------|------------------------------|--------------------|
| Top | 00h | 02h |
| Second | 04h | 06h |

The interrupt line stays asserted until both tiers are empty. A handler therefore has to clear the top tier and the second tier before `smi_n` returns high.

Output sequencing is held by a two-state machine:
- `SMI_IDLE`: the line is high. It moves to `SMI_ACTIVE` on the transition *raise*, taken on any clock edge where a status bit is set.
- `SMI_ACTIVE`: the line is low. It returns to `SMI_IDLE` on the transition *release*, taken on a clock edge where both tiers are empty.

Top module: `smi_status_ctrl`

## Requirements
- R1: After reset, both tiers read zero and `smi_n` is high.
- R2: Second-tier bits are sticky, with this layout: bit 0 is timer 1, bit 1 is timer 2, bits 2 to 4 are traps 1 to 3, and bit 5 is the PCI trap. Bits 15:6 read as zero. A bit stays set after its pulse ends.
- R3: Any second-tier event sets top-tier bit 9 on the same clock edge.
- R4: `top_evt[n]` sets top-tier bit n (sticky) for every n other than 9. `top_evt[9]` has no effect.
- R5: A read of offset 00h returns the top tier and leaves it unchanged.
- R6: A read of offset 02h returns the top tier and clears it on that clock edge. The second tier is not affected.
- R7: A read of offset 04h returns the second tier unchanged. A read of offset 06h returns it and clears it.
- R8: A read of any other offset returns zero and changes no state.
- R9: `smi_n` goes low one clock after any status bit becomes set. It goes high one clock after both tiers become empty.
- R10: An event that coincides with a clearing read is kept set after the clear. The read still returns the value from before the clear.
- R11: `rd_data` is zero while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_evt | input | 2 | Timer 1 and 2 event pulses |
| utrap_evt | input | 3 | User trap 1 to 3 event pulses |
| pci_trap_evt | input | 1 | PCI address trap event pulse |
| top_evt | input | 16 | Direct top-tier event pulses (bit 9 unused) |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 8 | I/O offset of the read |
| rd_data | output | 16 | Read data (combinational, pre-clear value) |
| smi_n | output | 1 | Active-low interrupt request |

## Verification
The following are checked every cycle by assertions:
- Status bits hold their value when no clear is requested.
- A clear with no coincident event empties a tier.
- A second-tier event always sets the top summary bit.
- Mirror reads and unmapped reads leave state stable.
- An event that collides with a clear survives.
- `smi_n` follows pending status with one cycle of lag in both directions.

Only the bench scenarios can show the following: the exact bit layout of each tier, the values returned by each offset, the fact that `top_evt[9]` is ignored, and the handler sequence in which the line stays low after only the top tier has been cleared.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int L2_W   = 6;
    localparam int SUMMARY_BIT = 9;

    localparam logic [ADDR_W-1:0] OFS_TOP_MIRROR = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_TOP_CLEAR  = 8'h02;
    localparam logic [ADDR_W-1:0] OFS_L2_MIRROR  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_L2_CLEAR   = 8'h06;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_TOP  = 2'd1,
        RSEL_L2   = 2'd2
    } rsel_e;

    typedef enum logic {
        SMI_IDLE   = 1'b0,
        SMI_ACTIVE = 1'b1
    } smi_state_e;
endpackage

// File: rtl/smi_sticky_reg.sv
module smi_sticky_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else begin
            // clear first, then merge new events so none are lost (R10)
            q_r <= (clr_i ? '0 : q_r) | set_i;
        end
    end

    assign q_o = q_r;

    // R2: without a clear no bit ever drops
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));

    // R6/R7: a clear with no new event empties the register
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (set_i == '0)) |=> (q_o == '0));
endmodule

// File: rtl/smi_rd_decode.sv
module smi_rd_decode
    import smi_pkg::*;
(
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output rsel_e             sel_o,
    output logic              clr_top_o,
    output logic              clr_l2_o
);
    always_comb begin
        sel_o     = RSEL_NONE;
        clr_top_o = 1'b0;
        clr_l2_o  = 1'b0;
        if (rd_en_i) begin
            unique case (rd_addr_i)
                OFS_TOP_MIRROR: sel_o = RSEL_TOP;
                OFS_TOP_CLEAR: begin
                    sel_o     = RSEL_TOP;
                    clr_top_o = 1'b1;
                end
                OFS_L2_MIRROR: sel_o = RSEL_L2;
                OFS_L2_CLEAR: begin
                    sel_o    = RSEL_L2;
                    clr_l2_o = 1'b1;
                end
                default: sel_o = RSEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/smi_out_fsm.sv
module smi_out_fsm
    import smi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic smi_n_o
);
    smi_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMI_IDLE:   if (pending_i)  state_d = SMI_ACTIVE; // raise
            SMI_ACTIVE: if (!pending_i) state_d = SMI_IDLE;   // release
            default:    state_d = SMI_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SMI_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        smi_n_o = (state_q != SMI_ACTIVE);
    end

    // R9: line follows pending status one cycle later
    p_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pending_i |=> !smi_n_o);
    p_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> smi_n_o);
endmodule

// File: rtl/smi_status_ctrl.sv
module smi_status_ctrl
    import smi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tmr_evt,
    input  logic [2:0]        utrap_evt,
    input  logic              pci_trap_evt,
    input  logic [DATA_W-1:0] top_evt,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              smi_n
);
    localparam logic [DATA_W-1:0] SUM_MASK = DATA_W'(1) << SUMMARY_BIT;

    logic [L2_W-1:0]   l2_set, l2_q;
    logic [DATA_W-1:0] top_set, top_q;
    logic              clr_top, clr_l2, pending;
    rsel_e             sel;

    assign l2_set  = {pci_trap_evt, utrap_evt, tmr_evt};
    assign top_set = (top_evt & ~SUM_MASK) | ({DATA_W{|l2_set}} & SUM_MASK);

    smi_rd_decode u_dec (
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .sel_o     (sel),
        .clr_top_o (clr_top),
        .clr_l2_o  (clr_l2)
    );

    smi_sticky_reg #(.W(DATA_W)) u_top (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (top_set),
        .clr_i (clr_top),
        .q_o   (top_q)
    );

    smi_sticky_reg #(.W(L2_W)) u_l2 (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (l2_set),
        .clr_i (clr_l2),
        .q_o   (l2_q)
    );

    assign pending = (|top_q) | (|l2_q);

    smi_out_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .smi_n_o   (smi_n)
    );

    always_comb begin
        unique case (sel)
            RSEL_TOP: rd_data = top_q;
            RSEL_L2:  rd_data = {{(DATA_W-L2_W){1'b0}}, l2_q};
            default:  rd_data = '0;
        endcase
    end

    p_summary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|l2_set) |=> top_q[SUMMARY_BIT]);

    p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == OFS_TOP_MIRROR && top_set == '0) |=> $stable(top_q));

    p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != OFS_TOP_MIRROR && rd_addr != OFS_TOP_CLEAR &&
         rd_addr != OFS_L2_MIRROR && rd_addr != OFS_L2_CLEAR &&
         top_set == '0 && l2_set == '0) |=> ($stable(top_q) && $stable(l2_q)));

    p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_top && top_set[0]) |=> top_q[0]);
endmodule

// File: tb/smi_status_ctrl_bench.sv
`timescale 1ns/1ps
module smi_status_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tmr_evt = '0;
    logic [2:0]  utrap_evt = '0;
    logic        pci_trap_evt = 1'b0;
    logic [15:0] top_evt = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        smi_n;

    int checks = 0;
    int failures = 0;
    logic [15:0] v;

    always #2.5 clk = ~clk;

    smi_status_ctrl u_smi_status_ctrl (
        .clk(clk), .rst_n(rst_n), .tmr_evt(tmr_evt), .utrap_evt(utrap_evt),
        .pci_trap_evt(pci_trap_evt), .top_evt(top_evt), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .smi_n(smi_n)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_l2(input int idx);
        @(negedge clk);
        if (idx < 2)      tmr_evt[idx] = 1'b1;
        else if (idx < 5) utrap_evt[idx-2] = 1'b1;
        else              pci_trap_evt = 1'b1;
        @(negedge clk);
        tmr_evt = '0; utrap_evt = '0; pci_trap_evt = 1'b0;
    endtask

    task automatic pulse_top(input logic [15:0] m);
        @(negedge clk); top_evt = m;
        @(negedge clk); top_evt = '0;
    endtask

    task automatic t_reset();
        chk("R1 smi_n", {15'd0, smi_n}, 16'h0001);
        rd(8'h00, v); chk("R1 top", v, 16'h0000);
        rd(8'h04, v); chk("R1 l2", v, 16'h0000);
    endtask

    task automatic t_layout();
        for (int i = 0; i < 6; i++) begin
            pulse_l2(i);
            @(negedge clk);
            chk("R9 low", {15'd0, smi_n}, 16'h0000);
            rd(8'h04, v); chk("R2 R7 mirror l2", v, 16'(1 << i));
            rd(8'h00, v); chk("R3 summary", v, 16'h0200);
            rd(8'h06, v); chk("R7 clear l2", v, 16'(1 << i));
            rd(8'h04, v); chk("R7 l2 empty", v, 16'h0000);
            rd(8'h02, v); chk("R6 clear top", v, 16'h0200);
            @(negedge clk);
            chk("R9 high", {15'd0, smi_n}, 16'h0001);
        end
    endtask

    task automatic t_top_direct();
        pulse_top(16'hFFFF);
        rd(8'h00, v); chk("R4 top_evt bit9 ignored", v, 16'hFDFF);
        rd(8'h00, v); chk("R5 mirror no clear", v, 16'hFDFF);
        rd(8'h02, v); chk("R6 clear read", v, 16'hFDFF);
        rd(8'h00, v); chk("R6 cleared", v, 16'h0000);
        @(negedge clk);
        chk("R9 high after top", {15'd0, smi_n}, 16'h0001);
    endtask

    task automatic t_tiers();
        pulse_l2(1);
        rd(8'h02, v); chk("R6 top read", v, 16'h0200);
        rd(8'h04, v); chk("R6 l2 kept", v, 16'h0002);
        @(negedge clk);
        chk("R9 still low", {15'd0, smi_n}, 16'h0000);
        rd(8'h06, v); chk("R7 l2 clear", v, 16'h0002);
        @(negedge clk);
        chk("R9 released", {15'd0, smi_n}, 16'h0001);
    endtask

    task automatic t_unmapped();
        pulse_top(16'h0001);
        pulse_l2(5);
        rd(8'h01, v); chk("R8 01h zero", v, 16'h0000);
        rd(8'h08, v); chk("R8 08h zero", v, 16'h0000);
        rd(8'hFF, v); chk("R8 FFh zero", v, 16'h0000);
        rd(8'h00, v); chk("R8 top intact", v, 16'h0201);
        rd(8'h04, v); chk("R8 l2 intact", v, 16'h0020);
        @(negedge clk); rd_addr = 8'h00; #1
        chk("R11 idle data", rd_data, 16'h0000);
    endtask

    task automatic t_collide();
        // top currently 0x0201, l2 0x0020
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'h02; top_evt = 16'h0008;
        #1 chk("R10 pre-clear top", rd_data, 16'h0201);
        @(negedge clk);
        rd_en = 1'b0; top_evt = '0;
        rd(8'h00, v); chk("R10 top event kept", v, 16'h0008);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'h06; utrap_evt = 3'b001;
        #1 chk("R10 pre-clear l2", rd_data, 16'h0020);
        @(negedge clk);
        rd_en = 1'b0; utrap_evt = '0;
        rd(8'h04, v); chk("R10 l2 event kept", v, 16'h0004);
        rd(8'h06, v);
        rd(8'h02, v); chk("R10 top", v, 16'h0208);
        @(negedge clk);
        chk("R9 final high", {15'd0, smi_n}, 16'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_top_direct();
        t_tiers();
        t_unmapped();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule